// File: doc/BRIEF.md
# Bridgeless PFC Phase Steering Logic

This block is the digital glue for a two-channel interleaved bridgeless boost power-factor corrector of the totem-pole kind. Two sampled line comparators report whether the AC input sits above a positive threshold or below a negative one. The block synchronises them and builds two line-phase flags, one per polarity. Each flag comes from its own detector, so the pair is symmetrical and not one signal and its inverse. The flags are interlocked so that they are never high together. A blanking timer freezes them after every change, so that ringing near the zero crossing cannot flip them.

The flags then steer two paths. The first is the zero-current sense path: each channel's inductor has a centre-tapped sense winding, and the block passes that channel's positive-polarity or negative-polarity tap to the core controller's zero-current input. The second is the gate path: the core controller's two gate pulses go to the boost switches of the active half-cycle. Channel 1 drives switch 2 or switch 1. Channel 2 drives switch 4 or switch 3. Each channel's pulse stays on its own leg, so the 180-degree interleave set by the controller is kept. In the idle band around a zero crossing, all gates are low and both zero-current outputs sit at their inactive level.

Top module: `pfc_phase_steer`

## Requirements
- R1: Each comparator input passes through a two-flop synchroniser. When the blanking timer has expired and the interlock allows it, a level applied before a rising edge shows on the phase flag after the third rising edge.
- R2: The positive flag sets when the synchronised positive comparator is high and the negative flag is low, and clears when that comparator is low. The negative flag works the same way with the negative comparator.
- R3: The two flags are never high in the same cycle. A flag can only rise while the other flag is low. If both synchronised comparators are high while both flags are low, the positive flag rises and the negative flag stays low.
- R4: Any change of either flag starts a blanking window of BLANK_CYC cycles. During that window both flags hold, whatever the comparators do. The next change happens no earlier than BLANK_CYC+1 cycles after the previous one.
- R5: While the positive flag is high, zcd1_o and zcd2_o equal zcd1_p_i and zcd2_p_i as sampled one cycle earlier.
- R6: While the negative flag is high, zcd1_o and zcd2_o equal zcd1_n_i and zcd2_n_i as sampled one cycle earlier.
- R7: While the positive flag is high, gate_s2_o equals pwm1_i and gate_s4_o equals pwm2_i, each one cycle late, and gate_s1_o and gate_s3_o are low.
- R8: While the negative flag is high, gate_s1_o equals pwm1_i and gate_s3_o equals pwm2_i, each one cycle late, and gate_s2_o and gate_s4_o are low.
- R9: While both flags are low, all four gate outputs are low and both zero-current outputs equal the ZCD_IDLE parameter.
- R10: The gate outputs change on the same edge as the flags, so the gates of the group that loses its flag are low in that same cycle. No gate of one group is high together with any gate of the other group, and the gap between groups is at least BLANK_CYC+1 cycles.
- R11: While rst_ni is low, both flags and all gates are low and both zero-current outputs equal ZCD_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_pos_i | input | 1 | Line above the positive threshold (asynchronous) |
| cmp_neg_i | input | 1 | Line below the negative threshold (asynchronous) |
| zcd1_p_i | input | 1 | Channel 1 sense tap, positive-half polarity |
| zcd1_n_i | input | 1 | Channel 1 sense tap, negative-half polarity |
| zcd2_p_i | input | 1 | Channel 2 sense tap, positive-half polarity |
| zcd2_n_i | input | 1 | Channel 2 sense tap, negative-half polarity |
| pwm1_i | input | 1 | Channel 1 gate pulse from the core controller |
| pwm2_i | input | 1 | Channel 2 gate pulse from the core controller |
| zcd1_o | output | 1 | Channel 1 zero-current signal to the controller |
| zcd2_o | output | 1 | Channel 2 zero-current signal to the controller |
| gate_s1_o | output | 1 | Switch 1 gate (channel 1, negative group) |
| gate_s2_o | output | 1 | Switch 2 gate (channel 1, positive group) |
| gate_s3_o | output | 1 | Switch 3 gate (channel 2, negative group) |
| gate_s4_o | output | 1 | Switch 4 gate (channel 2, positive group) |
| ph_pos_o | output | 1 | Positive half-cycle flag |
| ph_neg_o | output | 1 | Negative half-cycle flag |

## Verification
The properties assume that the sense taps and the gate pulses come from the same clock domain and are sampled once without a synchroniser. The comparators are the only asynchronous inputs. No property assumes the comparators are well behaved: the stimulus deliberately drives chatter shorter than the blanking window, long idle bands, and the illegal case with both comparators high. It holds the sense and gate inputs as random levels that are stable around each rising edge, because the bench drives every input on the falling edge.

// File: rtl/pfc_steer_pkg.sv
package pfc_steer_pkg;
  localparam int NUM_CH  = 2;
  localparam int IDX_POS = 0;
  localparam int IDX_NEG = 1;

  typedef logic [1:0]        pol_vec_t;   // [IDX_POS], [IDX_NEG]
  typedef logic [NUM_CH-1:0] ch_vec_t;    // one bit per channel
endpackage

// File: rtl/pfc_sync2.sv
module pfc_sync2 #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pfc_blank_timer.sv
module pfc_blank_timer #(
  parameter int BLANK_CYC = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic hold_o
);
  localparam int CW = (BLANK_CYC < 1) ? 1 : $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(BLANK_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign hold_o = (cnt_q != '0);
endmodule

// File: rtl/pfc_phase_det.sv
module pfc_phase_det #(
  parameter bit YIELD = 1'b0  // loses a tie against the rival detector
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_i,
  input  logic rival_cmp_i,
  input  logic rival_flag_i,
  input  logic hold_i,
  output logic flag_o,
  output logic flag_nxt_o
);
  logic flag_q;
  logic rise, fall;

  assign rise = !flag_q && cmp_i && !rival_flag_i && !(YIELD && rival_cmp_i);
  assign fall = flag_q && !cmp_i;

  always_comb begin
    flag_nxt_o = flag_q;
    if (!hold_i) begin
      if (rise)      flag_nxt_o = 1'b1;
      else if (fall) flag_nxt_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_nxt_o;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pfc_route.sv
module pfc_route
  import pfc_steer_pkg::*;
#(
  parameter bit ZCD_IDLE = 1'b0
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    pos_nxt_i,
  input  logic    neg_nxt_i,
  input  ch_vec_t zcd_p_i,
  input  ch_vec_t zcd_n_i,
  input  ch_vec_t pwm_i,
  output ch_vec_t zcd_o,
  output ch_vec_t gate_pos_o,
  output ch_vec_t gate_neg_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic zcd_q, gp_q, gn_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        zcd_q <= ZCD_IDLE;
        gp_q  <= 1'b0;
        gn_q  <= 1'b0;
      end else begin
        gp_q <= pos_nxt_i && pwm_i[c];
        gn_q <= neg_nxt_i && pwm_i[c];
        if (pos_nxt_i)      zcd_q <= zcd_p_i[c];
        else if (neg_nxt_i) zcd_q <= zcd_n_i[c];
        else                zcd_q <= ZCD_IDLE;
      end
    end

    assign zcd_o[c]      = zcd_q;
    assign gate_pos_o[c] = gp_q;
    assign gate_neg_o[c] = gn_q;
  end
endmodule

// File: rtl/pfc_phase_steer.sv
module pfc_phase_steer
  import pfc_steer_pkg::*;
#(
  parameter int BLANK_CYC = 1024,
  parameter bit ZCD_IDLE  = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_pos_i,
  input  logic cmp_neg_i,
  input  logic zcd1_p_i,
  input  logic zcd1_n_i,
  input  logic zcd2_p_i,
  input  logic zcd2_n_i,
  input  logic pwm1_i,
  input  logic pwm2_i,
  output logic zcd1_o,
  output logic zcd2_o,
  output logic gate_s1_o,
  output logic gate_s2_o,
  output logic gate_s3_o,
  output logic gate_s4_o,
  output logic ph_pos_o,
  output logic ph_neg_o
);
  pol_vec_t cmp_raw, cmp_s, flag_q, flag_nxt;
  logic     hold, load;
  ch_vec_t  zcd_p, zcd_n, pwm, zcd, gate_pos, gate_neg;

  assign cmp_raw[IDX_POS] = cmp_pos_i;
  assign cmp_raw[IDX_NEG] = cmp_neg_i;

  pfc_sync2 #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_raw),
    .q_o   (cmp_s)
  );

  // Two independent detectors; the negative one yields on a tie.
  for (genvar p = 0; p < 2; p++) begin : g_det
    pfc_phase_det #(.YIELD(p == IDX_NEG)) u_det (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cmp_i       (cmp_s[p]),
      .rival_cmp_i (cmp_s[1-p]),
      .rival_flag_i(flag_q[1-p]),
      .hold_i      (hold),
      .flag_o      (flag_q[p]),
      .flag_nxt_o  (flag_nxt[p])
    );
  end

  assign load = (flag_nxt != flag_q);

  pfc_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .hold_o(hold)
  );

  assign zcd_p = {zcd2_p_i, zcd1_p_i};
  assign zcd_n = {zcd2_n_i, zcd1_n_i};
  assign pwm   = {pwm2_i, pwm1_i};

  pfc_route #(.ZCD_IDLE(ZCD_IDLE)) u_route (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pos_nxt_i (flag_nxt[IDX_POS]),
    .neg_nxt_i (flag_nxt[IDX_NEG]),
    .zcd_p_i   (zcd_p),
    .zcd_n_i   (zcd_n),
    .pwm_i     (pwm),
    .zcd_o     (zcd),
    .gate_pos_o(gate_pos),
    .gate_neg_o(gate_neg)
  );

  assign zcd1_o    = zcd[0];
  assign zcd2_o    = zcd[1];
  assign gate_s2_o = gate_pos[0];
  assign gate_s4_o = gate_pos[1];
  assign gate_s1_o = gate_neg[0];
  assign gate_s3_o = gate_neg[1];
  assign ph_pos_o  = flag_q[IDX_POS];
  assign ph_neg_o  = flag_q[IDX_NEG];
endmodule

// File: rtl/pfc_phase_steer_chk.sv
module pfc_phase_steer_chk #(
  parameter int BLANK_CYC = 1024,
  parameter bit ZCD_IDLE  = 1'b0
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cmp_pos_i,
  input logic cmp_neg_i,
  input logic zcd1_p_i,
  input logic zcd1_n_i,
  input logic zcd2_p_i,
  input logic zcd2_n_i,
  input logic pwm1_i,
  input logic pwm2_i,
  input logic zcd1_o,
  input logic zcd2_o,
  input logic gate_s1_o,
  input logic gate_s2_o,
  input logic gate_s3_o,
  input logic gate_s4_o,
  input logic ph_pos_o,
  input logic ph_neg_o
);
  localparam int CW = (BLANK_CYC < 1) ? 1 : $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(BLANK_CYC);

  logic [1:0]    flags, prev_q;
  logic [CW-1:0] since_q;
  logic          changed;

  assign flags   = {ph_neg_o, ph_pos_o};
  assign changed = (flags != prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 2'b00;
      since_q <= SAT;
    end else begin
      prev_q <= flags;
      if (changed)           since_q <= '0;
      else if (since_q != SAT) since_q <= since_q + 1'b1;
    end
  end

  p_flags_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ph_pos_o && ph_neg_o));

  p_blank_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    changed |-> (since_q == SAT));

  p_pos_zcd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_pos_o |-> (zcd1_o == $past(zcd1_p_i) && zcd2_o == $past(zcd2_p_i)));

  p_neg_zcd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_neg_o |-> (zcd1_o == $past(zcd1_n_i) && zcd2_o == $past(zcd2_n_i)));

  p_pos_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_pos_o |-> (gate_s2_o == $past(pwm1_i) && gate_s4_o == $past(pwm2_i)));

  p_neg_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_neg_o |-> (gate_s1_o == $past(pwm1_i) && gate_s3_o == $past(pwm2_i)));

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ph_pos_o && !ph_neg_o) |->
      ($countones({gate_s1_o, gate_s2_o, gate_s3_o, gate_s4_o}) == 0 &&
       zcd1_o == ZCD_IDLE && zcd2_o == ZCD_IDLE));

  p_group_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_s2_o || gate_s4_o) |-> (ph_pos_o && !gate_s1_o && !gate_s3_o));

  p_neg_group_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_s1_o || gate_s3_o) |-> ph_neg_o);
endmodule

bind pfc_phase_steer pfc_phase_steer_chk #(
  .BLANK_CYC(BLANK_CYC),
  .ZCD_IDLE (ZCD_IDLE)
) u_chk (.*);

// File: tb/pfc_phase_steer_bench.sv
module pfc_phase_steer_bench;
  localparam int LB = 8;
  localparam bit ZI = 1'b1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmp_pos = 0, cmp_neg = 0;
  logic z1p = 0, z1n = 0, z2p = 0, z2n = 0, pwm1 = 0, pwm2 = 0;
  logic zcd1, zcd2, gs1, gs2, gs3, gs4, php, phn;

  int checks = 0, fails = 0;
  bit mon = 0, done = 0;

  always #10 clk = ~clk;

  pfc_phase_steer #(.BLANK_CYC(LB), .ZCD_IDLE(ZI)) u_pfc_phase_steer (
    .clk_i(clk), .rst_ni(rst_n), .cmp_pos_i(cmp_pos), .cmp_neg_i(cmp_neg),
    .zcd1_p_i(z1p), .zcd1_n_i(z1n), .zcd2_p_i(z2p), .zcd2_n_i(z2n),
    .pwm1_i(pwm1), .pwm2_i(pwm2), .zcd1_o(zcd1), .zcd2_o(zcd2),
    .gate_s1_o(gs1), .gate_s2_o(gs2), .gate_s3_o(gs3), .gate_s4_o(gs4),
    .ph_pos_o(php), .ph_neg_o(phn)
  );

  // Reference model built from the requirements
  logic [1:0] m_s1, m_s2;
  logic m_pos, m_neg, m_z1, m_z2;
  logic [3:0] m_g;  // {s4,s3,s2,s1}
  int m_cnt;
  logic pn, nn;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_pos <= 0; m_neg <= 0; m_cnt <= 0;
      m_g <= 0; m_z1 <= ZI; m_z2 <= ZI;
    end else begin
      pn = m_pos; nn = m_neg;
      if (m_cnt == 0) begin
        pn = m_pos ? m_s2[0] : (m_s2[0] && !m_neg);
        nn = m_neg ? m_s2[1] : (m_s2[1] && !m_pos && !m_s2[0]);
      end
      m_cnt <= (pn != m_pos || nn != m_neg) ? LB : (m_cnt > 0 ? m_cnt - 1 : 0);
      m_pos <= pn; m_neg <= nn;
      m_g   <= {pn & pwm2, nn & pwm2, pn & pwm1, nn & pwm1};
      m_z1  <= pn ? z1p : (nn ? z1n : ZI);
      m_z2  <= pn ? z2p : (nn ? z2n : ZI);
      m_s2  <= m_s1;
      m_s1  <= {cmp_neg, cmp_pos};
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (mon) begin
    chk("R2 R3 flags", {6'b0, phn, php}, {6'b0, m_neg, m_pos});
    chk("R7 R8 gates", {4'b0, gs4, gs3, gs2, gs1}, {4'b0, m_g});
    chk("R5 R6 zcd",   {6'b0, zcd2, zcd1}, {6'b0, m_z2, m_z1});
    if (!m_pos && !m_neg)
      chk("R9 idle", {4'b0, gs4, gs3, gs2, gs1, zcd2, zcd1}, {6'b0, ZI, ZI});
    chk("R10 groups", {7'b0, (gs1 | gs3) & (gs2 | gs4)}, 8'h0);
  end

  task automatic rnd_side();
    {pwm1, pwm2, z1p, z1n, z2p, z2n} = 6'($urandom);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog R1 act=hung exp=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11: reset state
    pwm1 = 1; pwm2 = 1; z1p = 1; z2n = 1;
    @(negedge clk);
    chk("R11 reset", {php, phn, gs1, gs2, gs3, gs4, zcd1, zcd2}, {6'b0, ZI, ZI});
    rst_n = 1; mon = 1;
    pwm1 = 0; pwm2 = 0;
    // R1: latency through synchroniser
    @(negedge clk); cmp_pos = 1;
    @(negedge clk); chk("R1 lat1", {7'b0, php}, 8'h0);
    @(negedge clk); chk("R1 lat2", {7'b0, php}, 8'h0);
    @(negedge clk); chk("R1 lat3", {7'b0, php}, 8'h1);
    // R4: chatter to opposite phase is ignored during blanking
    cmp_pos = 0; cmp_neg = 1;
    for (int k = 1; k <= LB; k++) begin
      @(negedge clk); chk("R4 hold", {6'b0, phn, php}, 8'h1);
    end
    @(negedge clk); chk("R4 fall", {6'b0, phn, php}, 8'h0);
    for (int k = 1; k <= LB; k++) begin
      @(negedge clk); chk("R10 dead gap", {6'b0, phn, php}, 8'h0);
    end
    @(negedge clk); chk("R2 neg rise", {6'b0, phn, php}, 8'h2);
    // R3: tie from idle goes to the positive flag
    cmp_neg = 0;
    repeat (3 * LB) @(negedge clk);
    cmp_pos = 1; cmp_neg = 1;
    repeat (3) @(negedge clk);
    chk("R3 tie", {6'b0, phn, php}, 8'h1);
    // R7: gate pulse on positive group
    pwm1 = 1; pwm2 = 0;
    @(negedge clk);
    chk("R7 gate s2", {4'b0, gs4, gs3, gs2, gs1}, 8'h2);
    // Random phase segments with chatter, idle bands and illegal ties
    for (int seg = 0; seg < 500; seg++) begin
      int r, dwell;
      r = int'($urandom % 8);
      dwell = 1 + int'($urandom % (4 * LB));
      case (r)
        0, 1, 2: {cmp_neg, cmp_pos} = 2'b01;
        3, 4, 5: {cmp_neg, cmp_pos} = 2'b10;
        6:       {cmp_neg, cmp_pos} = 2'b00;
        default: {cmp_neg, cmp_pos} = 2'b11;
      endcase
      for (int c = 0; c < dwell; c++) begin
        rnd_side();
        @(negedge clk);
      end
    end
    @(negedge clk);
    finish_run();
  end
endmodule